// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether an incoming Ethernet frame is kept or dropped by looking at its destination MAC address. The receive path presents the frame one byte per strobe, and the first byte is flagged as start of frame. The block gathers the six destination bytes and applies a fixed priority chain. The receive enable gates everything. Promiscuous mode comes next, then the all-ones broadcast address, then a 64-bin hash lookup that the multicast bit steers to either the multicast or the unicast enable.

The decision is a one-cycle pulse that carries an accept flag and a two-bit reason. Accept and reason hold until the next decision. Alongside the decision, the block keeps the largest frame length the receive side and the transmit side will take under the present length configuration. Both limits are registered outputs.

Top module: `rx_addr_filter`

## Requirements
- R1: A byte strobe with `byte_sof` high restarts collection as address byte 1. Later strobes without `byte_sof` fill bytes 2 to 6. The cycle after the strobe of byte 6, `dec_valid` is high for exactly one cycle. Strobes after byte 6, and strobes without a preceding start, are ignored until the next start. `dec_accept` and `dec_reason` hold their values between decisions.
- R2: When `rx_enable` is low at the sixth byte, the decision is reject: `dec_accept`=0 and `dec_reason`=0.
- R3: When receive is enabled and `cfg_promisc` is high, the frame is accepted with reason 1, whatever the address and the other settings.
- R4: Otherwise, a destination of FF:FF:FF:FF:FF:FF is rejected (reason 0) when `cfg_no_bcast` is high, and accepted with reason 2 when it is low. The hash lookup is never consulted for this address.
- R5: A destination is multicast when bit 0 of its first byte is 1. A non-broadcast multicast destination goes to the hash lookup only when `cfg_mc_hash_en` is high; otherwise it is rejected.
- R6: A non-multicast destination goes to the hash lookup only when `cfg_uc_hash_en` is high; otherwise it is rejected.
- R7: The hash index is the XOR of the eight 6-bit slices of the 48-bit destination. In this 48-bit value the first byte occupies bits 47:40 and the sixth byte occupies bits 7:0. The frame is accepted with reason 3 when `hash_buckets[index]` is 1, and rejected otherwise.
- R8: When jumbo mode is off, `rx_max_len` is 1518, or 1538 when `cfg_long_frame` is high.
- R9: When jumbo mode is off, `tx_max_len` is 1518.
- R10: With `cfg_jumbo` high, both limits equal `jumbo_max_len` capped at 10240.
- R11: Synchronous active-high reset clears `dec_valid`, `dec_accept` and `dec_reason`, sets both limits to 1518, and discards any partly collected address.
- R12: The length limits are registered and follow a change of the length configuration one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive enable |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_no_bcast | input | 1 | Reject the broadcast address |
| cfg_mc_hash_en | input | 1 | Hash lookup for multicast destinations |
| cfg_uc_hash_en | input | 1 | Hash lookup for unicast destinations |
| hash_buckets | input | 64 | One accept bit per hash index |
| cfg_jumbo | input | 1 | Jumbo length mode |
| cfg_long_frame | input | 1 | Raise standard receive limit to 1538 |
| jumbo_max_len | input | 14 | Programmed jumbo limit |
| byte_valid | input | 1 | Byte strobe |
| byte_sof | input | 1 | Strobed byte is the first of a frame |
| byte_data | input | 8 | Frame byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted |
| dec_reason | output | 2 | 0 reject, 1 promiscuous, 2 broadcast, 3 hash |
| rx_max_len | output | 14 | Receive length limit |
| tx_max_len | output | 14 | Transmit length limit |

## Verification
Directed frames are applied under fixed settings. Broadcast is sent both with broadcast rejection on and with multicast hashing on and all bins set, which shows that broadcast is decided ahead of the hash. Multicast and unicast addresses are sent with each hash enable toggled, which shows that the multicast bit selects the correct enable. Bin patterns with a single bit set or a single bit cleared separate a correct XOR fold from a wrong slice order.

A restart partway through an address, bytes beyond the sixth, and gaps between strobes test the collection rules. Several hundred frames with random addresses, settings and bins then cover the mixed cases. Jumbo limits below and above the cap test the clamp.

// File: rtl/rx_filter_pkg.sv
package rx_filter_pkg;
  typedef enum logic [1:0] {
    RSN_REJECT  = 2'd0,
    RSN_PROMISC = 2'd1,
    RSN_BCAST   = 2'd2,
    RSN_HASH    = 2'd3
  } rsn_t;
endpackage

// File: rtl/rxf_addr_collect.sv
module rxf_addr_collect #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_valid,
  input  logic                    byte_sof,
  input  logic [7:0]              byte_data,
  output logic                    addr_done,
  output logic [8*ADDR_BYTES-1:0] addr_full
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam int SR_W  = 8 * (ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  sr;
  logic             collecting;

  assign collecting = (cnt != '0) && (cnt < CNT_W'(ADDR_BYTES));
  assign addr_done  = byte_valid &&
                      (byte_sof ? (ADDR_BYTES == 1) : (cnt == CNT_W'(ADDR_BYTES - 1)));
  assign addr_full  = {sr, byte_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      sr  <= '0;
    end else if (byte_valid && (byte_sof || collecting)) begin
      sr  <= {sr[SR_W-9:0], byte_data};
      cnt <= byte_sof ? CNT_W'(1) : cnt + CNT_W'(1);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/rxf_addr_hash.sv
module rxf_addr_hash #(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [HASH_W-1:0] hidx
);
  localparam int GROUPS = (ADDR_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W  = GROUPS * HASH_W;

  logic [PAD_W-1:0]  padded;
  logic [HASH_W-1:0] chain [GROUPS+1];

  assign padded   = PAD_W'(addr);
  assign chain[0] = '0;

  for (genvar g = 0; g < GROUPS; g++) begin : g_fold
    assign chain[g+1] = chain[g] ^ padded[g*HASH_W +: HASH_W];
  end

  assign hidx = chain[GROUPS];
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rx_filter_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int HASH_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fire,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [HASH_W-1:0]     hidx,
  input  logic                  rx_enable,
  input  logic                  cfg_promisc,
  input  logic                  cfg_no_bcast,
  input  logic                  cfg_mc_hash_en,
  input  logic                  cfg_uc_hash_en,
  input  logic [2**HASH_W-1:0]  hash_buckets,
  output logic                  dec_valid,
  output logic                  dec_accept,
  output rsn_t                  dec_reason
);
  logic is_bcast, is_mc, hash_on;
  logic nxt_acc;
  rsn_t nxt_rsn;

  assign is_bcast = &addr;
  assign is_mc    = addr[ADDR_W-8];
  assign hash_on  = is_mc ? cfg_mc_hash_en : cfg_uc_hash_en;

  always_comb begin
    nxt_acc = 1'b0;
    nxt_rsn = RSN_REJECT;
    if (!rx_enable) begin
      nxt_acc = 1'b0;
    end else if (cfg_promisc) begin
      nxt_acc = 1'b1;
      nxt_rsn = RSN_PROMISC;
    end else if (is_bcast) begin
      if (!cfg_no_bcast) begin
        nxt_acc = 1'b1;
        nxt_rsn = RSN_BCAST;
      end
    end else if (hash_on && hash_buckets[hidx]) begin
      nxt_acc = 1'b1;
      nxt_rsn = RSN_HASH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_reason <= RSN_REJECT;
    end else begin
      dec_valid <= fire;
      if (fire) begin
        dec_accept <= nxt_acc;
        dec_reason <= nxt_rsn;
      end
    end
  end

  p_disabled_rejects_r2: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !$past(rx_enable) |-> !dec_accept);
  p_promisc_wins_r3: assert property (@(posedge clk) disable iff (rst)
    dec_valid && $past(rx_enable) && $past(cfg_promisc) |-> dec_accept && dec_reason == RSN_PROMISC);
  p_no_bcast_r4: assert property (@(posedge clk) disable iff (rst)
    dec_valid && $past(cfg_no_bcast) && !$past(cfg_promisc) |-> dec_reason != RSN_BCAST);
  p_reason_agrees_r7: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_accept == (dec_reason != RSN_REJECT)));
endmodule

// File: rtl/rxf_len_limit.sv
module rxf_len_limit #(
  parameter int LEN_W      = 14,
  parameter int STD_LEN    = 1518,
  parameter int LONG_LEN   = 1538,
  parameter int JUMBO_CEIL = 10240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_jumbo,
  input  logic             cfg_long_frame,
  input  logic [LEN_W-1:0] jumbo_max_len,
  output logic [LEN_W-1:0] rx_max_len,
  output logic [LEN_W-1:0] tx_max_len
);
  localparam logic [LEN_W-1:0] STD_L  = LEN_W'(STD_LEN);
  localparam logic [LEN_W-1:0] LONG_L = LEN_W'(LONG_LEN);
  localparam logic [LEN_W-1:0] CEIL_L = LEN_W'(JUMBO_CEIL);
  localparam logic [LEN_W-1:0] TOP_L  = (CEIL_L > LONG_L) ? CEIL_L : LONG_L;

  logic [LEN_W-1:0] jumbo_lim;
  assign jumbo_lim = (jumbo_max_len > CEIL_L) ? CEIL_L : jumbo_max_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_max_len <= STD_L;
      tx_max_len <= STD_L;
    end else if (cfg_jumbo) begin
      rx_max_len <= jumbo_lim;
      tx_max_len <= jumbo_lim;
    end else begin
      rx_max_len <= cfg_long_frame ? LONG_L : STD_L;
      tx_max_len <= STD_L;
    end
  end

  p_rx_not_below_tx_r9: assert property (@(posedge clk) disable iff (rst)
    rx_max_len >= tx_max_len);
  p_ceiling_r10: assert property (@(posedge clk) disable iff (rst)
    rx_max_len <= TOP_L);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_filter_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 14,
  parameter int STD_LEN    = 1518,
  parameter int LONG_LEN   = 1538,
  parameter int JUMBO_CEIL = 10240
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_enable,
  input  logic                cfg_promisc,
  input  logic                cfg_no_bcast,
  input  logic                cfg_mc_hash_en,
  input  logic                cfg_uc_hash_en,
  input  logic [2**HASH_W-1:0] hash_buckets,
  input  logic                cfg_jumbo,
  input  logic                cfg_long_frame,
  input  logic [LEN_W-1:0]    jumbo_max_len,
  input  logic                byte_valid,
  input  logic                byte_sof,
  input  logic [7:0]          byte_data,
  output logic                dec_valid,
  output logic                dec_accept,
  output logic [1:0]          dec_reason,
  output logic [LEN_W-1:0]    rx_max_len,
  output logic [LEN_W-1:0]    tx_max_len
);
  localparam int ADDR_W = 8 * ADDR_BYTES;

  logic              addr_done;
  logic [ADDR_W-1:0] addr_full;
  logic [HASH_W-1:0] hidx;
  rsn_t              reason;

  rxf_addr_collect #(.ADDR_BYTES(ADDR_BYTES)) u_collect (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_data(byte_data), .addr_done(addr_done), .addr_full(addr_full)
  );

  rxf_addr_hash #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_hash (
    .addr(addr_full), .hidx(hidx)
  );

  rxf_decide #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_decide (
    .clk(clk), .rst(rst), .fire(addr_done), .addr(addr_full), .hidx(hidx),
    .rx_enable(rx_enable), .cfg_promisc(cfg_promisc), .cfg_no_bcast(cfg_no_bcast),
    .cfg_mc_hash_en(cfg_mc_hash_en), .cfg_uc_hash_en(cfg_uc_hash_en),
    .hash_buckets(hash_buckets), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_reason(reason)
  );

  assign dec_reason = reason;

  rxf_len_limit #(.LEN_W(LEN_W), .STD_LEN(STD_LEN), .LONG_LEN(LONG_LEN),
                  .JUMBO_CEIL(JUMBO_CEIL)) u_len (
    .clk(clk), .rst(rst), .cfg_jumbo(cfg_jumbo), .cfg_long_frame(cfg_long_frame),
    .jumbo_max_len(jumbo_max_len), .rx_max_len(rx_max_len), .tx_max_len(tx_max_len)
  );

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_enable = 1'b0, cfg_promisc = 1'b0, cfg_no_bcast = 1'b0;
  logic        cfg_mc_hash_en = 1'b0, cfg_uc_hash_en = 1'b0;
  logic [63:0] hash_buckets = '0;
  logic        cfg_jumbo = 1'b0, cfg_long_frame = 1'b0;
  logic [13:0] jumbo_max_len = '0;
  logic        byte_valid = 1'b0, byte_sof = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_reason;
  logic [13:0] rx_max_len, tx_max_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .cfg_promisc(cfg_promisc),
    .cfg_no_bcast(cfg_no_bcast), .cfg_mc_hash_en(cfg_mc_hash_en),
    .cfg_uc_hash_en(cfg_uc_hash_en), .hash_buckets(hash_buckets),
    .cfg_jumbo(cfg_jumbo), .cfg_long_frame(cfg_long_frame),
    .jumbo_max_len(jumbo_max_len), .byte_valid(byte_valid), .byte_sof(byte_sof),
    .byte_data(byte_data), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_reason(dec_reason), .rx_max_len(rx_max_len), .tx_max_len(tx_max_len)
  );

  // reference model state
  int          m_cnt = 0;
  logic [47:0] m_da = '0;
  logic        e_valid = 0, e_accept = 0;
  int          e_reason = 0, e_rx = 1518, e_tx = 1518;
  string       e_tag = "R11", l_tag = "R11";
  bit          armed = 0, after_rst = 0;

  function automatic int fold_hash(logic [47:0] da);
    int idx = 0;
    for (int g = 0; g < 8; g++) idx = idx ^ int'((da >> (6 * g)) & 48'h3f);
    return idx;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      string dt = after_rst ? "R11" : "R1";
      string vt = after_rst ? "R11" : e_tag;
      string lt = after_rst ? "R11" : l_tag;
      check(dec_valid == e_valid, dt, "dec_valid", int'(dec_valid), int'(e_valid));
      check(dec_accept == e_accept, vt, "dec_accept", int'(dec_accept), int'(e_accept));
      check(int'(dec_reason) == e_reason, vt, "dec_reason", int'(dec_reason), e_reason);
      check(int'(rx_max_len) == e_rx, lt, "rx_max_len", int'(rx_max_len), e_rx);
      check(int'(tx_max_len) == e_tx, (lt == "R8") ? "R9" : lt, "tx_max_len", int'(tx_max_len), e_tx);
    end
    if (rst) begin
      m_cnt = 0; e_valid = 0; e_accept = 0; e_reason = 0;
      e_rx = 1518; e_tx = 1518; armed = 1; after_rst = 1;
    end else begin
      after_rst = 0;
      e_valid = 0;
      if (byte_valid) begin
        if (byte_sof) begin
          m_cnt = 1; m_da = {40'd0, byte_data};
        end else if (m_cnt >= 1 && m_cnt < 6) begin
          m_da = (m_da << 8) | {40'd0, byte_data};
          m_cnt++;
          if (m_cnt == 6) begin
            e_valid = 1; e_accept = 0; e_reason = 0;
            if (!rx_enable) e_tag = "R2";
            else if (cfg_promisc) begin e_accept = 1; e_reason = 1; e_tag = "R3"; end
            else if (m_da == 48'hFFFF_FFFF_FFFF) begin
              e_tag = "R4";
              if (!cfg_no_bcast) begin e_accept = 1; e_reason = 2; end
            end else if (m_da[40] && !cfg_mc_hash_en) e_tag = "R5";
            else if (!m_da[40] && !cfg_uc_hash_en) e_tag = "R6";
            else begin
              e_tag = "R7";
              if (hash_buckets[fold_hash(m_da)]) begin e_accept = 1; e_reason = 3; end
            end
          end
        end
      end
      if (cfg_jumbo) begin
        e_rx = (jumbo_max_len > 14'd10240) ? 10240 : int'(jumbo_max_len);
        e_tx = e_rx; l_tag = "R10";
      end else begin
        e_rx = cfg_long_frame ? 1538 : 1518; e_tx = 1518; l_tag = "R8";
      end
      if (l_tag == "R8" && (int'(rx_max_len) != e_rx)) l_tag = "R12";
    end
  end

  task automatic put_byte(logic [7:0] b, logic sof);
    @(posedge clk); #2;
    byte_valid = 1'b1; byte_sof = sof; byte_data = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      byte_valid = 1'b0; byte_sof = 1'b0;
    end
  endtask

  task automatic send_addr(logic [47:0] da, bit gaps);
    for (int i = 0; i < 6; i++) begin
      put_byte(da[47 - 8*i -: 8], i == 0);
      if (gaps && ($urandom % 3 == 0)) idle(1);
    end
    idle(2);
  endtask

  task automatic set_cfg(bit en, bit pr, bit nb, bit mh, bit uh);
    @(posedge clk); #2;
    rx_enable = en; cfg_promisc = pr; cfg_no_bcast = nb;
    cfg_mc_hash_en = mh; cfg_uc_hash_en = uh;
  endtask

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MC_A  = 48'h0100_5E12_3456;
  localparam logic [47:0] UC_A  = 48'h0012_3456_789A;

  initial begin
    idle(3);
    @(posedge clk); #2; rst = 1'b0;
    idle(2);
    // R2: receive disabled
    set_cfg(0, 1, 0, 1, 1); hash_buckets = '1;
    send_addr(BCAST, 0); send_addr(UC_A, 0);
    // R3: promiscuous
    set_cfg(1, 1, 1, 0, 0);
    send_addr(BCAST, 0); send_addr(MC_A, 1); send_addr(UC_A, 0);
    // R4: broadcast, ahead of multicast hash with all bins set
    set_cfg(1, 0, 0, 1, 1); send_addr(BCAST, 0);
    set_cfg(1, 0, 1, 1, 1); send_addr(BCAST, 1);
    // R5 / R6: hash enables selected by the multicast bit
    set_cfg(1, 0, 0, 0, 1); send_addr(MC_A, 0); send_addr(UC_A, 0);
    set_cfg(1, 0, 0, 1, 0); send_addr(MC_A, 0); send_addr(UC_A, 0);
    // R7: single bin set / single bin cleared
    set_cfg(1, 0, 0, 1, 1);
    hash_buckets = 64'd1 << fold_hash(UC_A); send_addr(UC_A, 0); send_addr(MC_A, 0);
    hash_buckets = ~(64'd1 << fold_hash(MC_A)); send_addr(MC_A, 0); send_addr(UC_A, 0);
    // R1: restart mid-address, trailing bytes, orphan bytes
    hash_buckets = '1;
    put_byte(8'h01, 1); put_byte(8'h02, 0); put_byte(8'h03, 0);
    send_addr(UC_A, 0);
    put_byte(8'h11, 0); put_byte(8'h22, 0); put_byte(8'h33, 0); put_byte(8'h44, 0);
    put_byte(8'h55, 0); put_byte(8'h66, 0); put_byte(8'h77, 0); idle(2);
    put_byte(8'hAA, 1); for (int i = 0; i < 5; i++) put_byte(8'h00, 0);
    put_byte(8'hBB, 1); for (int i = 0; i < 5; i++) put_byte(8'h10 + 8'(i), 0);
    idle(3);
    // R8 / R9 / R10 / R12: length limits
    @(posedge clk); #2; cfg_long_frame = 1; idle(2);
    @(posedge clk); #2; cfg_long_frame = 0; idle(2);
    @(posedge clk); #2; cfg_jumbo = 1; jumbo_max_len = 14'd9000; idle(2);
    @(posedge clk); #2; jumbo_max_len = 14'd10240; idle(2);
    @(posedge clk); #2; jumbo_max_len = 14'd16000; idle(2);
    @(posedge clk); #2; cfg_long_frame = 1; jumbo_max_len = 14'd1000; idle(2);
    @(posedge clk); #2; cfg_jumbo = 0; idle(2);
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [47:0] da;
      int sel = $urandom % 4;
      da = {$urandom, $urandom} ;
      if (sel == 0) da = BCAST;
      else if (sel == 1) da[40] = 1'b1;
      else da[40] = 1'b0;
      @(posedge clk); #2;
      rx_enable = ($urandom % 8) != 0; cfg_promisc = ($urandom % 6) == 0;
      cfg_no_bcast = $urandom; cfg_mc_hash_en = $urandom; cfg_uc_hash_en = $urandom;
      hash_buckets = {$urandom, $urandom};
      cfg_jumbo = ($urandom % 4) == 0; cfg_long_frame = $urandom;
      jumbo_max_len = 14'($urandom);
      send_addr(da, 1);
    end
    // reset in the middle of an address
    put_byte(8'h00, 1); put_byte(8'h01, 0); put_byte(8'h02, 0);
    @(posedge clk); #2; byte_valid = 0; rst = 1;
    @(posedge clk); #2; rst = 0;
    put_byte(8'h03, 0); put_byte(8'h04, 0); put_byte(8'h05, 0); idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule